// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block moves a processor from one task to another by walking two task-state records in memory. When a switch request is accepted, it takes a snapshot of the current architectural state, which is eight general registers, six segment selectors, the instruction pointer and the flags. It then writes that snapshot into the outgoing record. After that it reads the incoming record and delivers its contents to the register file in a single commit cycle.

All traffic goes through one word-wide request/acknowledge memory port, one access at a time. The page-table base of the incoming task is fetched first and handed to the paging unit before any other incoming field is read, so every later read uses the new mapping. For call and interrupt switches, the sequencer then writes the outgoing task's selector into the back-link word of the incoming record. A bus error at any point aborts the sequence and leaves the architectural registers untouched, because incoming values are held in shadow registers until the commit.

Each field sits at a word offset from its record base, and each offset is set by a parameter. Field addresses are `base + 4*offset`.

Top module: `ctx_swap_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `mem_req`, `pt_valid`, `ld_en`, `done` and `fault` are all low.
- R2: An accepted switch issues exactly 16 writes to the outgoing record, in this order: general registers 0..7 at `old_base+4*(GPR_OFS+i)`, selectors 0..5 zero-extended at `old_base+4*(SEG_OFS+i)`, instruction pointer at `IP_OFS`, flags at `FLG_OFS`. The values written are the ones on the `cur_*` ports in the cycle the request was accepted.
- R3: No read of the incoming record is issued until all 16 outgoing writes have completed.
- R4: The first read is the page-table base at `new_base+4*PTB_OFS`. In the cycle after that read completes, `pt_valid` is high for one cycle with the word on `pt_base` and `mem_req` low. No other read precedes that pulse.
- R5: After the page-table base, the block reads general registers 0..7, selectors 0..5, instruction pointer, flags and the local-descriptor selector, in that order, from the incoming record. When `ld_en` is high, the `ld_*` outputs carry those values, with each selector taken from the low 16 bits of its word.
- R6: For cause 2'b01 (call) or 2'b10 (interrupt), exactly one write of `old_sel` zero-extended to `new_base+4*LINK_OFS` follows the last read. For cause 2'b00 (jump) or 2'b11 (treated as jump), there is no such write.
- R7: While `mem_req` is high and neither `mem_ack` nor `mem_err` is high, the next cycle keeps `mem_req` high with `mem_addr`, `mem_we` and `mem_wdata` unchanged.
- R8: `mem_err` on an access ends the sequence. `fault` pulses in the next cycle, no further access is issued, and `ld_en` and `done` do not rise for that switch.
- R9: After a clean sequence, `ld_en` is high for exactly one cycle and `done` is high for exactly one cycle, in the cycle after `ld_en`.
- R10: `req_valid` while `busy` is high is ignored. It does not alter the running switch's addresses, and it is not queued as a further switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Switch request, accepted when idle |
| req_cause | input | 2 | 00 jump, 01 call, 10 interrupt, 11 treated as jump |
| req_old_base | input | ADDR_W | Byte base of outgoing record |
| req_new_base | input | ADDR_W | Byte base of incoming record |
| req_old_sel | input | SEL_W | Outgoing task selector for the back-link |
| cur_gpr | input | 8*WORD_W | Current general registers, register i at bits [32i+31:32i] |
| cur_seg | input | 6*SEL_W | Current selectors, selector i at bits [16i+15:16i] |
| cur_ip | input | WORD_W | Current instruction pointer |
| cur_flags | input | WORD_W | Current flags |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed |
| pt_valid | output | 1 | Page-table base handoff strobe |
| pt_base | output | WORD_W | Incoming page-table base |
| ld_en | output | 1 | Commit strobe for the register file |
| ld_gpr | output | 8*WORD_W | Incoming general registers |
| ld_seg | output | 6*SEL_W | Incoming selectors |
| ld_ip | output | WORD_W | Incoming instruction pointer |
| ld_flags | output | WORD_W | Incoming flags |
| ld_ldt | output | SEL_W | Incoming local-descriptor selector |
| busy | output | 1 | Switch in progress |
| done | output | 1 | Switch completed pulse |
| fault | output | 1 | Switch aborted by bus error |

## Verification
The assertions check, on every cycle, the properties that local port history can decide. These are request holding under wait states, the page-table base being the first incoming read and its handoff preceding every other read, the rule that any write after a read must be the back-link of a call or interrupt, the abort after an error, and the one-cycle spacing of commit and done. Only the bench scenarios can show the full access sequence with the right data at every address. They also show the register values presented at commit, that selectors are zero-extended, and that a request arriving mid-switch is neither obeyed nor queued. The bench runs these scenarios under random wait states, with errors injected at chosen access positions.

// File: rtl/ctx_swap_pkg.sv
`timescale 1ns/1ps
package ctx_swap_pkg;
    localparam int WORD_W = 32;
    localparam int SEL_W  = 16;
    localparam int N_GPR  = 8;
    localparam int N_SEG  = 6;
    localparam int N_ARCH = N_GPR + N_SEG + 2;
    localparam int FLD_W  = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [FLD_W-1:0]  fld_t;

    // field codes: 0..7 general, 8..13 selectors, then ip, flags, ptb, ldt, link
    localparam fld_t FLD_SEG0 = fld_t'(N_GPR);
    localparam fld_t FLD_IP   = fld_t'(N_GPR + N_SEG);
    localparam fld_t FLD_FLG  = fld_t'(N_GPR + N_SEG + 1);
    localparam fld_t FLD_PTB  = fld_t'(N_ARCH);
    localparam fld_t FLD_LDT  = fld_t'(N_ARCH + 1);
    localparam fld_t FLD_LINK = fld_t'(N_ARCH + 2);

    typedef enum logic [1:0] {
        CAUSE_JUMP = 2'b00,
        CAUSE_CALL = 2'b01,
        CAUSE_INTR = 2'b10,
        CAUSE_RSVD = 2'b11
    } cause_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SAVE, ST_PTB, ST_PTOUT, ST_LOAD,
        ST_LINK, ST_COMMIT, ST_DONE, ST_FAULT
    } sw_state_e;

    typedef struct packed {
        logic [N_GPR-1:0][WORD_W-1:0] gpr;
        logic [N_SEG-1:0][SEL_W-1:0]  seg;
        word_t                        ip;
        word_t                        flg;
    } ctx_t;

    typedef struct packed {
        logic req;
        logic we;
        fld_t fld;
    } bus_op_t;

    function automatic logic cause_links(input logic [1:0] c);
        return (c == CAUSE_CALL) || (c == CAUSE_INTR);
    endfunction

    function automatic word_t sel_to_word(input sel_t s);
        return {{(WORD_W-SEL_W){1'b0}}, s};
    endfunction
endpackage

// File: rtl/css_seq_ctrl.sv
`timescale 1ns/1ps
module css_seq_ctrl
    import ctx_swap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_cause,
    input  logic       mem_ack,
    input  logic       mem_err,
    output bus_op_t    op,
    output logic       accept,
    output logic       load_we,
    output logic       pt_cap,
    output logic       pt_valid,
    output logic       ld_en,
    output logic       done,
    output logic       fault,
    output logic       busy
);
    sw_state_e state;
    fld_t      idx;
    logic      link_q;
    logic      xfer;

    assign accept = (state == ST_IDLE) && req_valid;
    assign xfer   = op.req && mem_ack && !mem_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            link_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    state  <= ST_SAVE;
                    idx    <= '0;
                    link_q <= cause_links(req_cause);
                end
                ST_SAVE: begin
                    if (mem_err) state <= ST_FAULT;
                    else if (mem_ack) begin
                        if (idx == FLD_FLG) begin
                            state <= ST_PTB;
                            idx   <= '0;
                        end else idx <= idx + fld_t'(1);
                    end
                end
                ST_PTB: begin
                    if (mem_err) state <= ST_FAULT;
                    else if (mem_ack) state <= ST_PTOUT;
                end
                ST_PTOUT: begin
                    state <= ST_LOAD;
                    idx   <= '0;
                end
                ST_LOAD: begin
                    if (mem_err) state <= ST_FAULT;
                    else if (mem_ack) begin
                        if (idx == FLD_LDT) state <= link_q ? ST_LINK : ST_COMMIT;
                        else if (idx == FLD_FLG) idx <= FLD_LDT;
                        else idx <= idx + fld_t'(1);
                    end
                end
                ST_LINK: begin
                    if (mem_err) state <= ST_FAULT;
                    else if (mem_ack) state <= ST_COMMIT;
                end
                ST_COMMIT: state <= ST_DONE;
                ST_DONE:   state <= ST_IDLE;
                ST_FAULT:  state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        op.req = (state == ST_SAVE) || (state == ST_PTB) ||
                 (state == ST_LOAD) || (state == ST_LINK);
        op.we  = (state == ST_SAVE) || (state == ST_LINK);
        if (state == ST_PTB)       op.fld = FLD_PTB;
        else if (state == ST_LINK) op.fld = FLD_LINK;
        else                       op.fld = idx;
    end

    assign load_we  = xfer && (state == ST_LOAD);
    assign pt_cap   = xfer && (state == ST_PTB);
    assign pt_valid = (state == ST_PTOUT);
    assign ld_en    = (state == ST_COMMIT);
    assign done     = (state == ST_DONE);
    assign fault    = (state == ST_FAULT);
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/css_addr_gen.sv
`timescale 1ns/1ps
module css_addr_gen
    import ctx_swap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GPR_OFS  = 4,
    parameter int SEG_OFS  = 12,
    parameter int IP_OFS   = 2,
    parameter int FLG_OFS  = 3,
    parameter int PTB_OFS  = 1,
    parameter int LDT_OFS  = 18,
    parameter int LINK_OFS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] old_base,
    input  logic [ADDR_W-1:0] new_base,
    input  bus_op_t           op,
    output logic [ADDR_W-1:0] addr
);
    localparam int BYTE_SH = $clog2(WORD_W / 8);

    logic [ADDR_W-1:0] old_q, new_q, base;
    int                ofs;

    always_ff @(posedge clk) begin
        if (rst) begin
            old_q <= '0;
            new_q <= '0;
        end else if (accept) begin
            old_q <= old_base;
            new_q <= new_base;
        end
    end

    always_comb begin
        if (op.fld < FLD_SEG0)       ofs = GPR_OFS + int'(op.fld);
        else if (op.fld < FLD_IP)    ofs = SEG_OFS + int'(op.fld) - int'(FLD_SEG0);
        else if (op.fld == FLD_IP)   ofs = IP_OFS;
        else if (op.fld == FLD_FLG)  ofs = FLG_OFS;
        else if (op.fld == FLD_PTB)  ofs = PTB_OFS;
        else if (op.fld == FLD_LDT)  ofs = LDT_OFS;
        else                         ofs = LINK_OFS;
        // saved architectural fields go to the outgoing record; all else to the incoming one
        base = (op.we && op.fld < FLD_PTB) ? old_q : new_q;
        addr = base + (ADDR_W'(ofs) << BYTE_SH);
    end
endmodule

// File: rtl/css_ctx_store.sv
`timescale 1ns/1ps
module css_ctx_store
    import ctx_swap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  ctx_t  cur,
    input  sel_t  old_sel,
    input  logic  load_we,
    input  logic  pt_cap,
    input  fld_t  fld,
    input  word_t rdata,
    output word_t wdata,
    output ctx_t  nxt,
    output sel_t  ldt,
    output word_t ptb
);
    ctx_t  snap_q;
    sel_t  link_sel_q;
    word_t gpr_q [N_GPR];
    sel_t  seg_q [N_SEG];
    word_t ip_q, flg_q, ptb_q;
    sel_t  ldt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q     <= '0;
            link_sel_q <= '0;
        end else if (accept) begin
            snap_q     <= cur;
            link_sel_q <= old_sel;
        end
    end

    for (genvar g = 0; g < N_GPR; g++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (rst) gpr_q[g] <= '0;
            else if (load_we && fld == fld_t'(g)) gpr_q[g] <= rdata;
        end
    end

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) seg_q[s] <= '0;
            else if (load_we && fld == fld_t'(N_GPR + s)) seg_q[s] <= rdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_q  <= '0;
            flg_q <= '0;
            ldt_q <= '0;
            ptb_q <= '0;
        end else begin
            if (load_we && fld == FLD_IP)  ip_q  <= rdata;
            if (load_we && fld == FLD_FLG) flg_q <= rdata;
            if (load_we && fld == FLD_LDT) ldt_q <= rdata[SEL_W-1:0];
            if (pt_cap)                    ptb_q <= rdata;
        end
    end

    always_comb begin
        wdata = '0;
        for (int i = 0; i < N_GPR; i++)
            if (fld == fld_t'(i)) wdata = snap_q.gpr[i];
        for (int i = 0; i < N_SEG; i++)
            if (fld == fld_t'(N_GPR + i)) wdata = sel_to_word(snap_q.seg[i]);
        if (fld == FLD_IP)   wdata = snap_q.ip;
        if (fld == FLD_FLG)  wdata = snap_q.flg;
        if (fld == FLD_LINK) wdata = sel_to_word(link_sel_q);
    end

    always_comb begin
        for (int i = 0; i < N_GPR; i++) nxt.gpr[i] = gpr_q[i];
        for (int i = 0; i < N_SEG; i++) nxt.seg[i] = seg_q[i];
        nxt.ip  = ip_q;
        nxt.flg = flg_q;
    end

    assign ldt = ldt_q;
    assign ptb = ptb_q;
endmodule

// File: rtl/ctx_swap_seq.sv
`timescale 1ns/1ps
module ctx_swap_seq
    import ctx_swap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GPR_OFS  = 4,
    parameter int SEG_OFS  = 12,
    parameter int IP_OFS   = 2,
    parameter int FLG_OFS  = 3,
    parameter int PTB_OFS  = 1,
    parameter int LDT_OFS  = 18,
    parameter int LINK_OFS = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [1:0]              req_cause,
    input  logic [ADDR_W-1:0]       req_old_base,
    input  logic [ADDR_W-1:0]       req_new_base,
    input  logic [SEL_W-1:0]        req_old_sel,
    input  logic [N_GPR*WORD_W-1:0] cur_gpr,
    input  logic [N_SEG*SEL_W-1:0]  cur_seg,
    input  logic [WORD_W-1:0]       cur_ip,
    input  logic [WORD_W-1:0]       cur_flags,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORD_W-1:0]       mem_wdata,
    input  logic [WORD_W-1:0]       mem_rdata,
    input  logic                    mem_ack,
    input  logic                    mem_err,
    output logic                    pt_valid,
    output logic [WORD_W-1:0]       pt_base,
    output logic                    ld_en,
    output logic [N_GPR*WORD_W-1:0] ld_gpr,
    output logic [N_SEG*SEL_W-1:0]  ld_seg,
    output logic [WORD_W-1:0]       ld_ip,
    output logic [WORD_W-1:0]       ld_flags,
    output logic [SEL_W-1:0]        ld_ldt,
    output logic                    busy,
    output logic                    done,
    output logic                    fault
);
    bus_op_t op;
    logic    accept, load_we, pt_cap;
    ctx_t    cur_ctx, nxt_ctx;

    always_comb begin
        cur_ctx.gpr = cur_gpr;
        cur_ctx.seg = cur_seg;
        cur_ctx.ip  = cur_ip;
        cur_ctx.flg = cur_flags;
    end

    css_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_cause(req_cause),
        .mem_ack  (mem_ack),
        .mem_err  (mem_err),
        .op       (op),
        .accept   (accept),
        .load_we  (load_we),
        .pt_cap   (pt_cap),
        .pt_valid (pt_valid),
        .ld_en    (ld_en),
        .done     (done),
        .fault    (fault),
        .busy     (busy)
    );

    css_addr_gen #(
        .ADDR_W(ADDR_W), .GPR_OFS(GPR_OFS), .SEG_OFS(SEG_OFS), .IP_OFS(IP_OFS),
        .FLG_OFS(FLG_OFS), .PTB_OFS(PTB_OFS), .LDT_OFS(LDT_OFS), .LINK_OFS(LINK_OFS)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .old_base(req_old_base),
        .new_base(req_new_base),
        .op      (op),
        .addr    (mem_addr)
    );

    css_ctx_store u_store (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .cur    (cur_ctx),
        .old_sel(req_old_sel),
        .load_we(load_we),
        .pt_cap (pt_cap),
        .fld    (op.fld),
        .rdata  (mem_rdata),
        .wdata  (mem_wdata),
        .nxt    (nxt_ctx),
        .ldt    (ld_ldt),
        .ptb    (pt_base)
    );

    assign mem_req  = op.req;
    assign mem_we   = op.we;
    assign ld_gpr   = nxt_ctx.gpr;
    assign ld_seg   = nxt_ctx.seg;
    assign ld_ip    = nxt_ctx.ip;
    assign ld_flags = nxt_ctx.flg;
endmodule

// File: rtl/ctx_swap_chk.sv
`timescale 1ns/1ps
module ctx_swap_chk
    import ctx_swap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PTB_OFS  = 1,
    parameter int LINK_OFS = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_cause,
    input logic [ADDR_W-1:0] req_new_base,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              mem_err,
    input logic              pt_valid,
    input logic              ld_en,
    input logic              done,
    input logic              fault,
    input logic              busy
);
    logic [ADDR_W-1:0] nb_q;
    logic [1:0]        cause_q;
    logic [5:0]        rd_cnt;
    logic              pt_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            nb_q    <= '0;
            cause_q <= '0;
            rd_cnt  <= '0;
            pt_seen <= 1'b0;
        end else if (!busy) begin
            rd_cnt  <= '0;
            pt_seen <= 1'b0;
            if (req_valid) begin
                nb_q    <= req_new_base;
                cause_q <= req_cause;
            end
        end else begin
            if (mem_req && !mem_we && mem_ack && !mem_err) rd_cnt <= rd_cnt + 6'd1;
            if (pt_valid) pt_seen <= 1'b1;
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !mem_err) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R4
    ptb_first_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_req && !mem_we && rd_cnt == 6'd0) |->
        (mem_addr == nb_q + (ADDR_W'(PTB_OFS) << 2)));

    // R4
    pt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pt_valid |-> !mem_req);

    // R4
    pt_before_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_req && !mem_we && rd_cnt != 6'd0) |-> pt_seen);

    // R3 R6
    late_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_req && mem_we && rd_cnt != 6'd0) |->
        ((mem_addr == nb_q + (ADDR_W'(LINK_OFS) << 2)) && cause_links(cause_q)));

    // R8
    err_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_err) |=> (fault && !mem_req));

    // R8
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!ld_en && !done));

    // R9
    commit_done_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (done && !ld_en));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind ctx_swap_seq ctx_swap_chk #(
    .ADDR_W(ADDR_W), .PTB_OFS(PTB_OFS), .LINK_OFS(LINK_OFS)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cause(req_cause),
    .req_new_base(req_new_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .pt_valid(pt_valid), .ld_en(ld_en), .done(done),
    .fault(fault), .busy(busy)
);

// File: tb/sim_ctx_swap_seq.sv
`timescale 1ns/1ps
module sim_ctx_swap_seq;
    localparam int GPR_OFS = 4, SEG_OFS = 12, IP_OFS = 2, FLG_OFS = 3;
    localparam int PTB_OFS = 1, LDT_OFS = 18, LINK_OFS = 0;

    logic         clk = 1'b0, rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [1:0]   req_cause = '0;
    logic [31:0]  req_old_base = '0, req_new_base = '0;
    logic [15:0]  req_old_sel = '0;
    logic [255:0] cur_gpr = '0;
    logic [95:0]  cur_seg = '0;
    logic [31:0]  cur_ip = '0, cur_flags = '0;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic [31:0]  mem_rdata = '0;
    logic         mem_ack = 1'b0, mem_err = 1'b0;
    logic         pt_valid, ld_en, busy, done, fault;
    logic [31:0]  pt_base, ld_ip, ld_flags;
    logic [255:0] ld_gpr;
    logic [95:0]  ld_seg;
    logic [15:0]  ld_ldt;

    ctx_swap_seq u0 (.*);

    always #2 clk = ~clk;

    int errors = 0, checks = 0;
    bit finished = 1'b0;

    logic [31:0] mem [0:1023];
    int          log_cnt, err_at, wait_ctr, cyc;
    logic        lg_we   [64];
    logic [31:0] lg_addr [64], lg_data [64];
    logic        ex_we   [64];
    logic [31:0] ex_addr [64], ex_data [64];
    int          ex_n;
    int          ld_cnt, done_cnt, flt_cnt, pt_cnt, pt_at, ld_cyc, done_cyc;
    logic [31:0] pt_val, cap_ip, cap_flg;
    logic [255:0] cap_gpr;
    logic [95:0] cap_seg;
    logic [15:0] cap_ldt;
    bit          pend, hold_bad;
    logic [31:0] pend_addr, pend_wdata;
    logic        pend_we;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model and monitor
    always @(negedge clk) begin
        int widx;
        cyc++;
        if (ld_en) begin
            ld_cnt++; ld_cyc = cyc;
            cap_gpr = ld_gpr; cap_seg = ld_seg; cap_ip = ld_ip; cap_flg = ld_flags; cap_ldt = ld_ldt;
        end
        if (done) begin done_cnt++; done_cyc = cyc; end
        if (fault) flt_cnt++;
        if (pt_valid) begin pt_cnt++; pt_at = log_cnt; pt_val = pt_base; end
        if (mem_req && pend && (mem_addr != pend_addr || mem_we != pend_we || mem_wdata != pend_wdata))
            hold_bad = 1'b1;
        mem_ack = 1'b0;
        mem_err = 1'b0;
        pend = 1'b0;
        if (mem_req) begin
            if (wait_ctr != 0) begin
                wait_ctr--;
                pend = 1'b1; pend_addr = mem_addr; pend_we = mem_we; pend_wdata = mem_wdata;
            end else begin
                if (log_cnt == err_at) mem_err = 1'b1;
                else begin
                    mem_ack = 1'b1;
                    widx = int'(mem_addr[11:2]);
                    if (mem_we) mem[widx] = mem_wdata;
                    else mem_rdata = mem[widx];
                    if (log_cnt < 64) begin
                        lg_we[log_cnt] = mem_we;
                        lg_addr[log_cnt] = mem_addr;
                        lg_data[log_cnt] = mem_we ? mem_wdata : mem[widx];
                    end
                    log_cnt++;
                end
                wait_ctr = int'($urandom_range(0, 2));
            end
        end
    end

    task automatic add_exp(input logic we, input logic [31:0] a, input logic [31:0] d);
        ex_we[ex_n] = we; ex_addr[ex_n] = a; ex_data[ex_n] = d; ex_n++;
    endtask

    task automatic run_sw(input logic [1:0] cause, input int err_k, input bit stray);
        logic [31:0] ob, nb, g [8], ip, fl, ng [8], nip, nfl;
        logic [15:0] s [8], ns [8], nldt, osel;
        logic [31:0] nptb, wv;
        bit link, seq_ok;
        int first_bad, nbw;
        string tag;
        ob = ($urandom % 16) * 128;
        nb = (($urandom % 15) + 16) * 128;
        nbw = int'(nb >> 2);
        osel = 16'($urandom);
        link = (cause == 2'b01) || (cause == 2'b10);
        for (int i = 0; i < 8; i++) begin
            g[i] = $urandom; ng[i] = $urandom;
            mem[nbw + GPR_OFS + i] = ng[i];
        end
        for (int i = 0; i < 6; i++) begin
            s[i] = 16'($urandom);
            wv = $urandom; ns[i] = wv[15:0];
            mem[nbw + SEG_OFS + i] = wv;
        end
        ip = $urandom; fl = $urandom; nip = $urandom; nfl = $urandom;
        nptb = $urandom; wv = $urandom; nldt = wv[15:0];
        mem[nbw + IP_OFS] = nip; mem[nbw + FLG_OFS] = nfl;
        mem[nbw + PTB_OFS] = nptb; mem[nbw + LDT_OFS] = wv;
        mem[nbw + LINK_OFS] = 32'h5a5a_0000;
        ex_n = 0;
        for (int i = 0; i < 8; i++) add_exp(1'b1, ob + 4*(GPR_OFS + i), g[i]);
        for (int i = 0; i < 6; i++) add_exp(1'b1, ob + 4*(SEG_OFS + i), {16'h0, s[i]});
        add_exp(1'b1, ob + 4*IP_OFS, ip);
        add_exp(1'b1, ob + 4*FLG_OFS, fl);
        add_exp(1'b0, nb + 4*PTB_OFS, nptb);
        for (int i = 0; i < 8; i++) add_exp(1'b0, nb + 4*(GPR_OFS + i), ng[i]);
        for (int i = 0; i < 6; i++) add_exp(1'b0, nb + 4*(SEG_OFS + i), mem[nbw + SEG_OFS + i]);
        add_exp(1'b0, nb + 4*IP_OFS, nip);
        add_exp(1'b0, nb + 4*FLG_OFS, nfl);
        add_exp(1'b0, nb + 4*LDT_OFS, wv);
        if (link) add_exp(1'b1, nb + 4*LINK_OFS, {16'h0, osel});

        @(negedge clk); #1;
        log_cnt = 0; err_at = err_k; ld_cnt = 0; done_cnt = 0; flt_cnt = 0;
        pt_cnt = 0; pt_at = -1; hold_bad = 1'b0;
        for (int i = 0; i < 8; i++) cur_gpr[32*i +: 32] = g[i];
        for (int i = 0; i < 6; i++) cur_seg[16*i +: 16] = s[i];
        cur_ip = ip; cur_flags = fl;
        req_cause = cause; req_old_base = ob; req_new_base = nb; req_old_sel = osel;
        req_valid = 1'b1;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk); #1;
            if (stray && t == 6) begin
                req_valid = 1'b1; req_old_base = 32'h0000_0f00; req_new_base = 32'h0000_0f80;
                req_cause = 2'b01;
                for (int i = 0; i < 8; i++) cur_gpr[32*i +: 32] = ~g[i];
            end else req_valid = 1'b0;
            if (done_cnt != 0 || flt_cnt != 0) break;
        end
        repeat (3) begin @(negedge clk); #1; end
        tag = stray ? "R10" : "R9";
        chk(!busy && !mem_req, tag, "idle after switch (no queued request)", {30'b0, busy, mem_req}, 0);
        chk(!hold_bad, "R7", "request held stable while waiting", {31'b0, hold_bad}, 0);

        if (err_k < 0) begin
            chk(log_cnt == ex_n, link ? "R6" : "R2", "access count", log_cnt, ex_n);
            seq_ok = 1'b1; first_bad = 0;
            for (int i = 0; i < ex_n && i < log_cnt; i++)
                if (seq_ok && (lg_we[i] != ex_we[i] || lg_addr[i] != ex_addr[i] || lg_data[i] != ex_data[i])) begin
                    seq_ok = 1'b0; first_bad = i;
                end
            tag = (first_bad < 16) ? "R2" : (first_bad < 34 ? "R3/R5" : "R6");
            chk(seq_ok, tag, $sformatf("access %0d addr", first_bad), lg_addr[first_bad], ex_addr[first_bad]);
            chk(seq_ok, tag, $sformatf("access %0d data", first_bad), lg_data[first_bad], ex_data[first_bad]);
            chk(pt_cnt == 1 && pt_at == 17 && pt_val == nptb, "R4", "page base handoff position/value",
                pt_val, nptb);
            chk(ld_cnt == 1 && done_cnt == 1 && done_cyc == ld_cyc + 1 && flt_cnt == 0, "R9",
                "commit then done spacing", done_cyc - ld_cyc, 1);
            seq_ok = 1'b1;
            for (int i = 0; i < 8; i++) if (cap_gpr[32*i +: 32] != ng[i]) seq_ok = 1'b0;
            for (int i = 0; i < 6; i++) if (cap_seg[16*i +: 16] != ns[i]) seq_ok = 1'b0;
            chk(seq_ok && cap_ip == nip && cap_flg == nfl, "R5", "loaded registers", cap_ip, nip);
            chk(cap_ldt == nldt, "R5", "loaded ldt selector", {16'h0, cap_ldt}, {16'h0, nldt});
        end else begin
            chk(log_cnt == err_k && flt_cnt == 1, "R8", "abort position", log_cnt, err_k);
            chk(ld_cnt == 0 && done_cnt == 0, "R8", "no commit after error", ld_cnt + done_cnt, 0);
            seq_ok = 1'b1;
            for (int i = 0; i < err_k && i < log_cnt; i++)
                if (lg_addr[i] != ex_addr[i] || lg_we[i] != ex_we[i]) seq_ok = 1'b0;
            chk(seq_ok, "R8", "accesses before error", {31'b0, seq_ok}, 1);
            chk((err_k <= 16) ? (pt_cnt == 0) : (pt_cnt == 1), "R4", "handoff only after page base read",
                pt_cnt, (err_k <= 16) ? 0 : 1);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_ctr = 0; cyc = 0; log_cnt = 0; err_at = -1;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        #1;
        chk(!busy && !mem_req && !pt_valid && !ld_en && !done && !fault, "R1", "outputs in reset",
            {26'b0, busy, mem_req, pt_valid, ld_en, done, fault}, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(!busy && !mem_req && !pt_valid && !ld_en && !done && !fault, "R1", "outputs after reset",
            {26'b0, busy, mem_req, pt_valid, ld_en, done, fault}, 0);
        // directed
        run_sw(2'b00, -1, 1'b0);   // jump: no link (R6)
        run_sw(2'b01, -1, 1'b0);   // call: link (R6)
        run_sw(2'b10, -1, 1'b1);   // interrupt with stray request (R10)
        run_sw(2'b11, -1, 1'b0);   // reserved code acts as jump (R6)
        run_sw(2'b01, 0, 1'b0);    // error on first save write (R8)
        run_sw(2'b00, 16, 1'b0);   // error on page base read (R8)
        run_sw(2'b00, 33, 1'b0);   // error on last load read (R8)
        run_sw(2'b10, 34, 1'b0);   // error on link write (R8)
        run_sw(2'b00, -1, 1'b1);   // recovery after fault
        // random
        for (int n = 0; n < 24; n++) begin
            logic [1:0] c;
            int k;
            c = 2'($urandom);
            k = (($urandom % 6) == 0) ? int'($urandom % 34) : -1;
            run_sw(c, k, (k < 0) && ($urandom % 2 == 1));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule